// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

The block turns a single register access request (target device, register, direction, write data) into the bus transactions needed to reach that register on a switch sitting behind a shared management bus. A configured switch bus address chooses the access style. With address zero the switch answers every bus address itself, so the request is passed through as one bus transaction. With a non-zero address the switch answers only at that address, through a command register and a data register. The sequencer then polls the command register until its busy flag clears, writes the command (and, for writes, the data first), polls again, and for reads fetches the result from the data register.

The lower-level bus port is a request/acknowledge pair. `bus_req_o` stays high with stable address, register, direction and data until `bus_ack_i` is seen. `bus_err_i` and `bus_rdata_i` are valid in the acknowledge cycle. Each acknowledge ends one transaction. Results come back as a one-cycle `rsp_done_o` together with an error code and the read data.

Top module: `mgmt_seq`

## Requirements
- R1: With `cfg_sw_addr_i` equal to 0, a request produces exactly one bus transaction. That transaction uses bus address = requested device, register = requested register, and the request's direction and write data. This holds whatever the value of `cfg_multi_i`.
- R2: With a non-zero `cfg_sw_addr_i` and `cfg_multi_i` low, `cfg_err_o` is high. An accepted request then issues no bus transaction and completes with error code 3 (config).
- R3: In indirect mode, before a command is written, the block reads register 0 at the switch address repeatedly until bit 15 of the read value is 0.
- R4: A busy poll gives up after 16 reads. If bit 15 is still 1 on the 16th read, the request ends with error code 2 (timeout). If it is 0 on the 16th read, the sequence continues.
- R5: An indirect read performs, in order: the busy poll; a write to register 0 of the command word; a second busy poll; a read of register 1. The command word has bit 15 = 1, bit 12 = 1, bits 11:10 = 2'b10, bits 9:5 = device and bits 4:0 = register.
- R6: An indirect write performs, in order: the busy poll; a write of the data to register 1; a write to register 0 of the command word with bits 11:10 = 2'b01 and otherwise the same layout as the read command; a final busy poll.
- R7: A bus transaction acknowledged with `bus_err_i` high ends the request at once, with no further transaction and with error code 1 (bus).
- R8: Read data is the low 16 bits of the final bus read. Writes and failed requests return 0. Error code 0 means success.
- R9: A request is accepted only while `req_ready_o` is high, and requests presented while busy are ignored. `rsp_done_o` is high for exactly one cycle per accepted request.
- R10: While `bus_req_o` is high and not yet acknowledged, the bus request and its address, register, direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sw_addr_i | input | 5 | Switch bus address; 0 selects direct access |
| cfg_multi_i | input | 1 | Switch supports shared-bus indirect access |
| cfg_err_o | output | 1 | Configuration cannot be served |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dev_i | input | 5 | Internal device address |
| req_reg_i | input | 5 | Internal register address |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | One-cycle completion strobe |
| rsp_err_o | output | 2 | 0 ok, 1 bus, 2 timeout, 3 config |
| rsp_rdata_o | output | 16 | Read result |
| bus_req_o | output | 1 | Bus transaction request |
| bus_write_o | output | 1 | Bus transaction direction |
| bus_addr_o | output | 5 | Bus device address |
| bus_reg_o | output | 5 | Bus register address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_ack_i | input | 1 | Transaction complete |
| bus_err_i | input | 1 | Transaction failed, valid with ack |
| bus_rdata_i | input | 32 | Transaction read data, valid with ack |

## Verification
The stimulus covers the following cases:
- Direct reads and writes, including one with `cfg_multi_i` set. These show that address zero bypasses the indirect path.
- Indirect reads and writes with zero, a few and many busy polls before and after the command. These separate the read ordering from the write ordering and check each command word.
- Busy runs of 15 and 16 reads. These place the timeout exactly on the 16th poll.
- Errors injected at the first transaction, in the data write and in the second poll, plus an unsupported configuration. These show that the sequence aborts and that each failure gets its own code.

Every bus transaction is logged and compared against an independently built expected sequence. A request presented while busy checks that it is ignored.

// File: rtl/mgmt_seq_pkg.sv
package mgmt_seq_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BUS     = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_CFG     = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    MODE_DIRECT,
    MODE_INDIRECT,
    MODE_BAD
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REFUSE,
    ST_DIRECT,
    ST_POLL_PRE,
    ST_WDATA,
    ST_CMD,
    ST_POLL_POST,
    ST_RDATA
  } state_e;

endpackage

// File: rtl/mgmt_mode_dec.sv
module mgmt_mode_dec
  import mgmt_seq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] sw_addr_i,
  input  logic          multi_i,
  output mode_e         mode_o
);

  always_comb begin
    if (sw_addr_i == '0)  mode_o = MODE_DIRECT;
    else if (multi_i)     mode_o = MODE_INDIRECT;
    else                  mode_o = MODE_BAD;
  end

endmodule

// File: rtl/mgmt_cmd_fmt.sv
module mgmt_cmd_fmt #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic [AW-1:0] dev_i,
  input  logic [AW-1:0] reg_i,
  input  logic          write_i,
  output logic [DW-1:0] cmd_o
);

  localparam int DEV_LSB  = AW;
  localparam int OP_LSB   = 2 * AW;
  localparam int MODE_BIT = OP_LSB + 2;
  localparam int BUSY_BIT = DW - 1;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  always_comb begin
    cmd_o                 = '0;
    cmd_o[BUSY_BIT]       = 1'b1;
    cmd_o[MODE_BIT]       = 1'b1;
    cmd_o[OP_LSB +: 2]    = write_i ? OP_WR : OP_RD;
    cmd_o[DEV_LSB +: AW]  = dev_i;
    cmd_o[0 +: AW]        = reg_i;
  end

endmodule

// File: rtl/mgmt_poll_ctr.sv
module mgmt_poll_ctr #(
  parameter int POLL_MAX = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_MAX - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  // R4: the sequencer never advances the count past the last permitted poll
  a_r4_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !clr_i |-> !inc_i);

endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
  import mgmt_seq_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 16,
  parameter int RDW      = 32,
  parameter int POLL_MAX = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  cfg_sw_addr_i,
  input  logic           cfg_multi_i,
  output logic           cfg_err_o,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_write_i,
  input  logic [AW-1:0]  req_dev_i,
  input  logic [AW-1:0]  req_reg_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           rsp_done_o,
  output logic [1:0]     rsp_err_o,
  output logic [DW-1:0]  rsp_rdata_o,
  output logic           bus_req_o,
  output logic           bus_write_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [AW-1:0]  bus_reg_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic           bus_ack_i,
  input  logic           bus_err_i,
  input  logic [RDW-1:0] bus_rdata_i
);

  localparam int BUSY_BIT = DW - 1;
  localparam logic [AW-1:0] CMD_REG  = AW'(0);
  localparam logic [AW-1:0] DATA_REG = AW'(1);

  mode_e          mode_live;
  state_e         state_q, state_d;
  logic [AW-1:0]  sw_q, dev_q, reg_q;
  logic           wr_q;
  logic [DW-1:0]  wdata_q, cmd_word;
  logic           done_q;
  err_e           err_q, fin_err;
  logic [DW-1:0]  rdata_q;
  logic           finish, cap_rd, poll_clr, poll_inc, poll_last;
  logic           accept, busy_flag;

  generate
    if (RDW > DW) begin : g_wide
      logic unused_rd_hi;
      assign unused_rd_hi = ^bus_rdata_i[RDW-1:DW];
    end
  endgenerate

  mgmt_mode_dec #(.AW(AW)) u_mode (
    .sw_addr_i (cfg_sw_addr_i),
    .multi_i   (cfg_multi_i),
    .mode_o    (mode_live)
  );

  mgmt_cmd_fmt #(.AW(AW), .DW(DW)) u_cmd (
    .dev_i   (dev_q),
    .reg_i   (reg_q),
    .write_i (wr_q),
    .cmd_o   (cmd_word)
  );

  mgmt_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  assign cfg_err_o   = (mode_live == MODE_BAD);
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign busy_flag   = bus_rdata_i[BUSY_BIT];

  always_comb begin
    state_d  = state_q;
    finish   = 1'b0;
    fin_err  = ERR_NONE;
    cap_rd   = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          unique case (mode_live)
            MODE_DIRECT:   state_d = ST_DIRECT;
            MODE_INDIRECT: begin state_d = ST_POLL_PRE; poll_clr = 1'b1; end
            default:       state_d = ST_REFUSE;
          endcase
        end
      end
      ST_REFUSE: begin
        finish  = 1'b1;
        fin_err = ERR_CFG;
      end
      ST_DIRECT: begin
        if (bus_ack_i) begin
          finish = 1'b1;
          if (bus_err_i) fin_err = ERR_BUS;
          else           cap_rd  = !wr_q;
        end
      end
      ST_POLL_PRE, ST_POLL_POST: begin
        if (bus_ack_i) begin
          if (bus_err_i) begin
            finish  = 1'b1;
            fin_err = ERR_BUS;
          end else if (!busy_flag) begin
            poll_clr = 1'b1;
            if (state_q == ST_POLL_PRE) state_d = wr_q ? ST_WDATA : ST_CMD;
            else if (wr_q)              finish  = 1'b1;
            else                        state_d = ST_RDATA;
          end else if (poll_last) begin
            finish  = 1'b1;
            fin_err = ERR_TIMEOUT;
          end else begin
            poll_inc = 1'b1;
          end
        end
      end
      ST_WDATA: begin
        if (bus_ack_i) begin
          if (bus_err_i) begin finish = 1'b1; fin_err = ERR_BUS; end
          else           state_d = ST_CMD;
        end
      end
      ST_CMD: begin
        if (bus_ack_i) begin
          if (bus_err_i) begin
            finish  = 1'b1;
            fin_err = ERR_BUS;
          end else begin
            poll_clr = 1'b1;
            state_d  = ST_POLL_POST;
          end
        end
      end
      ST_RDATA: begin
        if (bus_ack_i) begin
          finish = 1'b1;
          if (bus_err_i) fin_err = ERR_BUS;
          else           cap_rd  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sw_q    <= '0;
      dev_q   <= '0;
      reg_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        sw_q    <= cfg_sw_addr_i;
        dev_q   <= req_dev_i;
        reg_q   <= req_reg_i;
        wr_q    <= req_write_i;
        wdata_q <= req_wdata_i;
      end
      if (finish) begin
        err_q   <= fin_err;
        rdata_q <= cap_rd ? bus_rdata_i[DW-1:0] : '0;
      end
    end
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_write_o = 1'b0;
    bus_addr_o  = sw_q;
    bus_reg_o   = CMD_REG;
    bus_wdata_o = '0;
    unique case (state_q)
      ST_IDLE, ST_REFUSE: bus_req_o = 1'b0;
      ST_DIRECT: begin
        bus_addr_o  = dev_q;
        bus_reg_o   = reg_q;
        bus_write_o = wr_q;
        bus_wdata_o = wdata_q;
      end
      ST_WDATA: begin
        bus_reg_o   = DATA_REG;
        bus_write_o = 1'b1;
        bus_wdata_o = wdata_q;
      end
      ST_CMD: begin
        bus_write_o = 1'b1;
        bus_wdata_o = cmd_word;
      end
      ST_RDATA: bus_reg_o = DATA_REG;
      default: ;
    endcase
  end

  assign rsp_done_o  = done_q;
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rdata_q;

  // R9: completion strobe lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  // R10: pending transaction held steady until acknowledged
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_reg_o)
      && $stable(bus_write_o) && $stable(bus_wdata_o));

  // R7: failed transaction ends the request at once
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_err_i |=> rsp_done_o && (rsp_err_o == ERR_BUS) && !bus_req_o);

  // R4: a timeout follows a busy read of the command register
  a_r4_timeout_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o && (rsp_err_o == ERR_TIMEOUT) |->
      $past(bus_ack_i && busy_flag && (bus_reg_o == CMD_REG) && !bus_write_o));

  // R2: unsupported configuration never reaches the bus
  a_r2_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cfg_err_o |=> !bus_req_o);

endmodule

// File: tb/mgmt_seq_tb_top.sv
`timescale 1ns/1ps
module mgmt_seq_tb_top;

  typedef struct packed {
    logic [4:0]  sw;
    logic        multi;
    logic        wr;
    logic [4:0]  dev;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [4:0]  bpre;
    logic [4:0]  bpost;
    logic [5:0]  err_at;
    logic [1:0]  xerr;
    logic [5:0]  xntx;
    logic [15:0] xrd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [0:NV-1] = '{
    '{5'd0, 1'b0, 1'b0, 5'd3,  5'd7,  16'h0000, 5'd0,  5'd0,  6'h3F, 2'd0, 6'd1,  16'h19D5},
    '{5'd0, 1'b0, 1'b1, 5'd17, 5'd2,  16'h1234, 5'd0,  5'd0,  6'h3F, 2'd0, 6'd1,  16'h0000},
    '{5'd4, 1'b1, 1'b0, 5'd5,  5'd9,  16'h0000, 5'd0,  5'd0,  6'h3F, 2'd0, 6'd4,  16'h2A55},
    '{5'd4, 1'b1, 1'b0, 5'd31, 5'd31, 16'h0000, 5'd3,  5'd5,  6'h3F, 2'd0, 6'd12, 16'hFFD5},
    '{5'd6, 1'b1, 1'b1, 5'd2,  5'd0,  16'hA5C3, 5'd1,  5'd2,  6'h3F, 2'd0, 6'd7,  16'h0000},
    '{5'd2, 1'b1, 1'b0, 5'd1,  5'd1,  16'h0000, 5'd16, 5'd0,  6'h3F, 2'd2, 6'd16, 16'h0000},
    '{5'd2, 1'b1, 1'b0, 5'd1,  5'd1,  16'h0000, 5'd15, 5'd0,  6'h3F, 2'd0, 6'd19, 16'h0855},
    '{5'd2, 1'b1, 1'b1, 5'd4,  5'd4,  16'h5A5A, 5'd0,  5'd20, 6'h3F, 2'd2, 6'd19, 16'h0000},
    '{5'd4, 1'b1, 1'b0, 5'd5,  5'd9,  16'h0000, 5'd0,  5'd0,  6'd2,  2'd1, 6'd3,  16'h0000},
    '{5'd0, 1'b0, 1'b0, 5'd3,  5'd7,  16'h0000, 5'd0,  5'd0,  6'd0,  2'd1, 6'd1,  16'h0000},
    '{5'd8, 1'b0, 1'b0, 5'd3,  5'd3,  16'h0000, 5'd0,  5'd0,  6'h3F, 2'd3, 6'd0,  16'h0000},
    '{5'd4, 1'b1, 1'b1, 5'd5,  5'd9,  16'hBEEF, 5'd0,  5'd0,  6'd1,  2'd1, 6'd2,  16'h0000},
    '{5'd0, 1'b1, 1'b0, 5'd31, 5'd0,  16'h0000, 5'd0,  5'd0,  6'h3F, 2'd0, 6'd1,  16'hF815}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_sw = '0;
  logic        cfg_multi = 1'b0;
  logic        cfg_err;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [4:0]  req_dev = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [1:0]  rsp_err;
  logic [15:0] rsp_rdata;
  logic        bus_req, bus_write;
  logic [4:0]  bus_addr, bus_reg;
  logic [15:0] bus_wdata;
  logic        bus_ack;
  logic        bus_err;
  logic [31:0] bus_rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mgmt_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_sw_addr_i(cfg_sw), .cfg_multi_i(cfg_multi), .cfg_err_o(cfg_err),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_dev_i(req_dev), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .bus_req_o(bus_req), .bus_write_o(bus_write), .bus_addr_o(bus_addr),
    .bus_reg_o(bus_reg), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_err_i(bus_err), .bus_rdata_i(bus_rdata)
  );

  // behavioural bus target
  logic        tgt_load = 1'b0;
  int          t_bpre = 0, t_bpost = 0, t_err_at = 63;
  int          t_ntx;
  int          busy_left;
  logic [15:0] dreg;
  logic        lg_w [0:31];
  logic [4:0]  lg_a [0:31];
  logic [4:0]  lg_r [0:31];
  logic [15:0] lg_d [0:31];
  logic        t_ind, is_poll;

  assign t_ind   = (cfg_sw != 5'd0);
  assign is_poll = t_ind && !bus_write && (bus_reg == 5'd0) && (bus_addr == cfg_sw);
  assign bus_err = bus_ack && (t_ntx == t_err_at);
  always_comb begin
    if (!t_ind)       bus_rdata = {16'hFFFF, bus_addr, bus_reg, 6'h15};
    else if (is_poll) bus_rdata = {16'h7777, (busy_left != 0), 15'h0};
    else              bus_rdata = {16'hC0DE, dreg};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; t_ntx <= 0; busy_left <= 0; dreg <= '0;
    end else if (tgt_load) begin
      t_ntx <= 0; busy_left <= t_bpre; bus_ack <= 1'b0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && bus_ack) begin
        if (t_ntx < 32) begin
          lg_w[t_ntx] <= bus_write; lg_a[t_ntx] <= bus_addr;
          lg_r[t_ntx] <= bus_reg;   lg_d[t_ntx] <= bus_wdata;
        end
        t_ntx <= t_ntx + 1;
        if (is_poll && busy_left != 0) busy_left <= busy_left - 1;
        if (t_ind && bus_write && bus_addr == cfg_sw && bus_reg == 5'd0) begin
          busy_left <= t_bpost;
          if (bus_wdata[11:10] == 2'b10) dreg <= {bus_wdata[9:5], bus_wdata[4:0], 6'h15};
        end
        if (t_ind && bus_write && bus_addr == cfg_sw && bus_reg == 5'd1) dreg <= bus_wdata;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.sw == 0)       return "R1";
    if (!v.multi)        return "R2";
    if (v.xerr == 2'd1)  return "R7";
    if (v.xerr == 2'd2)  return "R4";
    return v.wr ? "R6" : "R5";
  endfunction

  // expected k-th transaction, derived from the requirements
  task automatic exp_txn(input vec_t v, input int k, output logic w, output logic [4:0] a,
                         output logic [4:0] r, output logic [15:0] d);
    int npre, npost;
    logic [15:0] cmd;
    npre  = (v.bpre  >= 16) ? 16 : int'(v.bpre)  + 1;
    npost = (v.bpost >= 16) ? 16 : int'(v.bpost) + 1;
    cmd = 16'h9000 | (v.wr ? 16'h0400 : 16'h0800) | {6'd0, v.dev, v.rg};
    w = 1'b0; a = v.sw; r = 5'd0; d = 16'h0;
    if (v.sw == 0) begin
      w = v.wr; a = v.dev; r = v.rg; d = v.wd;
    end else if (k < npre) begin
    end else if (!v.wr) begin
      if (k == npre) begin w = 1'b1; d = cmd; end
      else if (k > npre + npost) r = 5'd1;
    end else begin
      if (k == npre)          begin w = 1'b1; r = 5'd1; d = v.wd; end
      else if (k == npre + 1) begin w = 1'b1; d = cmd; end
    end
  endtask

  task automatic run_req(input vec_t v, input bit poke_busy, output int pulses,
                         output logic [1:0] e, output logic [15:0] rd);
    @(negedge clk);
    cfg_sw = v.sw; cfg_multi = v.multi;
    t_bpre = int'(v.bpre); t_bpost = int'(v.bpost);
    t_err_at = (v.err_at == 6'h3F) ? 63 : int'(v.err_at);
    tgt_load = 1'b1;
    @(negedge clk);
    tgt_load = 1'b0;
    req_write = v.wr; req_dev = v.dev; req_reg = v.rg; req_wdata = v.wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    pulses = 0; e = 2'd0; rd = 16'h0;
    for (int c = 0; c < 110; c++) begin
      if (poke_busy && (c == 3 || c == 4)) begin
        req_valid = 1'b1; req_dev = 5'd1; req_reg = 5'd2; req_write = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      if (rsp_done) begin pulses++; e = rsp_err; rd = rsp_rdata; end
    end
    req_valid = 1'b0;
  endtask

  task automatic check_seq(input vec_t v, input string tg);
    logic w; logic [4:0] a, r; logic [15:0] d;
    bit ok = 1'b1;
    int n = (int'(v.xntx) < 32) ? int'(v.xntx) : 32;
    for (int k = 0; k < n; k++) begin
      exp_txn(v, k, w, a, r, d);
      if (lg_w[k] !== w || lg_a[k] !== a || lg_r[k] !== r || (w && lg_d[k] !== d)) begin
        ok = 1'b0;
        $display("FAIL %s R3 txn %0d: actual w=%0b a=%0d r=%0d d=%0h expected w=%0b a=%0d r=%0d d=%0h",
                 tg, k, lg_w[k], lg_a[k], lg_r[k], lg_d[k], w, a, r, d);
      end
    end
    n_chk++;
    if (!ok) n_fail++;
  endtask

  initial begin
    int pulses;
    logic [1:0] e;
    logic [15:0] rd;
    vec_t v;
    repeat (3) @(negedge clk);
    // reset state
    chk("R9", "ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R9", "done in reset", {31'd0, rsp_done}, 32'd0);
    chk("R10", "bus_req in reset", {31'd0, bus_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R8", "rdata after reset", {16'd0, rsp_rdata}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      run_req(v, 1'b0, pulses, e, rd);
      chk(tag_of(v), $sformatf("vec %0d error code", i), {30'd0, e}, {30'd0, v.xerr});
      chk("R8", $sformatf("vec %0d read data", i), {16'd0, rd}, {16'd0, v.xrd});
      chk(tag_of(v), $sformatf("vec %0d transaction count", i), t_ntx, {26'd0, v.xntx});
      chk("R9", $sformatf("vec %0d done pulses", i), pulses, 32'd1);
      check_seq(v, tag_of(v));
      chk("R2", $sformatf("vec %0d cfg_err", i), {31'd0, cfg_err},
          {31'd0, (v.sw != 0 && !v.multi)});
    end

    // request presented while busy is ignored
    v = VECS[2];
    v.bpre = 5'd5; v.xntx = 6'd9;
    run_req(v, 1'b1, pulses, e, rd);
    chk("R9", "busy request: done pulses", pulses, 32'd1);
    chk("R9", "busy request: transaction count", t_ntx, 32'd9);
    chk("R9", "busy request: result", {16'd0, rd}, 32'h2A55);
    check_seq(v, "R9");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule